// File: doc/BRIEF.md
# Sideband Mailbox Register Target

This block is the device end of a command mailbox between an external management host and an on-chip firmware agent. The host reaches it through a plain byte-wide register port: one address, one write strobe, write data, and read data that follows the address in the same cycle. In a chip this port sits behind a serial management target front end. The host loads a command code and a 32-bit argument into the inbound message bytes, then rings a doorbell register. The block captures the command and the argument at that write. It sends the firmware a one-cycle request and keeps the command stable until the firmware acknowledges it.

When the firmware finishes, it presents a 32-bit result with a completion strobe. The block stores the result in the outbound message bytes, where the host can read it but not write it. The same strobe sets a sticky status flag. This flag drives an alert line to the host unless a control bit masks it. The host clears the flag by writing a one to it. The host side resets through an asynchronous active-low input whose release is synchronised to the clock inside the block.

Top module: `sbmbox_top`

## Requirements
- R1: After reset the control register (address 0x01) reads 0x10, and the status register (0x02) reads 0x00. All message bytes read 0x00, the doorbell register (0x40) reads 0x00, and `host_alert` and `fw_req` are 0.
- R2: The eight inbound bytes at 0x38 to 0x3F can be written and read back by the host.
- R3: A host write to 0x40 with data bit 0 set, while no request is outstanding, raises `fw_req` for exactly one cycle, in the cycle after the write. At the same write, `fw_cmd` captures inbound byte 0 (0x38) and `fw_arg` captures bytes 1 to 4 (0x39 to 0x3C, least significant byte at 0x39). Both hold until the request is acknowledged, whatever the host writes later.
- R4: Register 0x40 reads 0x01 while a request is outstanding and clears in the cycle after `fw_ack`. A doorbell write while a request is outstanding gives no new pulse. A doorbell write with bit 0 clear has no effect.
- R5: On `fw_done`, `fw_resp` is loaded into outbound bytes 1 to 4 (0x31 to 0x34), least significant byte at 0x31. Outbound bytes 0, 5, 6 and 7 read 0x00.
- R6: Host writes to 0x30 to 0x37 leave the outbound bytes unchanged.
- R7: Status bit 1 is set by `fw_done` and stays set until the host writes 0x02-style data with bit 1 set to 0x02. Writing bit 1 as 0 leaves it set. If completion and the clearing write fall in the same cycle, the flag is set.
- R8: `host_alert` is 1 exactly when status bit 1 is 1 and control bit 4 is 0.
- R9: Reads of unmapped addresses (anything other than 0x01, 0x02 and 0x30 to 0x40) return 0x00, and writes to them change no register.
- R10: The control register holds and returns any 8-bit value the host writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| host_wr | input | 1 | Host write strobe, one write per cycle it is high |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, same cycle |
| host_alert | output | 1 | Completion alert to the host, active high |
| fw_req | output | 1 | One-cycle service request to firmware |
| fw_cmd | output | 8 | Captured command code |
| fw_arg | output | 8*ARG_BYTES | Captured command argument |
| fw_ack | input | 1 | Firmware accepts the outstanding request |
| fw_done | input | 1 | Firmware completion strobe |
| fw_resp | input | 8*ARG_BYTES | Firmware result, loaded on `fw_done` |

## Verification
The doorbell is rung twice with different command codes and arguments (0x02 with 0xDEADBEEF, then 0x04 with 0x00000001). This shows that the captured command follows the inbound bytes and that the byte order is right. An inbound byte is rewritten while a request is outstanding, which shows that the command is captured at the doorbell and not read live. A repeated doorbell write and a write with bit 0 clear tell a correct pending interlock apart from a design that simply sends a pulse on every write to 0x40. The status flag is exercised with a write-zero, a write-one, and a clear that lands in the same cycle as completion, with the alert compared under both mask settings. Unmapped addresses on both sides of each mapped range are read and written.

// File: rtl/sbmbox_pkg.sv
package sbmbox_pkg;

  localparam logic [7:0] ADR_CTRL     = 8'h01;
  localparam logic [7:0] ADR_STAT     = 8'h02;
  localparam logic [7:0] ADR_OUT_BASE = 8'h30;
  localparam logic [7:0] ADR_IN_BASE  = 8'h38;
  localparam logic [7:0] ADR_BELL     = 8'h40;

  localparam int unsigned MASK_BIT = 4;
  localparam int unsigned FLAG_BIT = 1;
  localparam int unsigned BELL_BIT = 0;

  localparam logic [7:0] CTRL_RESET = 8'h10;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic outb;
    logic inb;
    logic bell;
  } hit_t;

endpackage

// File: rtl/sbmbox_rstsync.sv
module sbmbox_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sbmbox_ctrlstat.sv
module sbmbox_ctrlstat
  import sbmbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       stat_we,
  input  logic [7:0] wdata,
  input  logic       fw_done,
  output logic [7:0] ctrl_q,
  output logic       flag_q,
  output logic       alert
);

  logic [7:0] ctrl_d;
  logic       flag_d;
  logic       flag_clr;

  always_comb begin
    ctrl_d   = ctrl_we ? wdata : ctrl_q;
    flag_clr = stat_we & wdata[FLAG_BIT];
    flag_d   = fw_done | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign alert = flag_q & ~ctrl_q[MASK_BIT];

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fw_done |=> flag_q);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(stat_we && wdata[FLAG_BIT])) |=> flag_q);

endmodule

// File: rtl/sbmbox_msgbank.sv
module sbmbox_msgbank #(
  parameter int unsigned MSG_BYTES = 8,
  parameter int unsigned ARG_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(MSG_BYTES),
  localparam int unsigned WORD_W   = 8 * ARG_BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_we,
  input  logic [IDX_W-1:0]       in_idx,
  input  logic [7:0]             wdata,
  input  logic                   out_load,
  input  logic [WORD_W-1:0]      resp,
  output logic [8*MSG_BYTES-1:0] in_bytes,
  output logic [8*MSG_BYTES-1:0] out_bytes
);

  for (genvar i = 0; i < MSG_BYTES; i++) begin : g_byte
    logic       in_en;
    logic [7:0] in_q;

    always_comb in_en = in_we && (in_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_q <= '0;
      else if (in_en) in_q <= wdata;
    end
    assign in_bytes[8*i +: 8] = in_q;

    if (i >= 1 && i <= ARG_BYTES) begin : g_resp
      logic [7:0] out_q;
      logic [7:0] out_d;
      always_comb out_d = resp[8*(i-1) +: 8];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_q <= '0;
        else if (out_load) out_q <= out_d;
      end
      assign out_bytes[8*i +: 8] = out_q;
    end else begin : g_zero
      assign out_bytes[8*i +: 8] = 8'h00;
    end
  end

  assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_load |=> $stable(out_bytes));

endmodule

// File: rtl/sbmbox_doorbell.sv
module sbmbox_doorbell #(
  parameter int unsigned ARG_BYTES = 4,
  localparam int unsigned WORD_W   = 8 * ARG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring,
  input  logic [7:0]        cmd_in,
  input  logic [WORD_W-1:0] arg_in,
  input  logic              fw_ack,
  output logic              pend_q,
  output logic              fw_req,
  output logic [7:0]        fw_cmd,
  output logic [WORD_W-1:0] fw_arg
);

  logic pend_d;
  logic req_d;
  logic snap_en;

  always_comb begin
    pend_d  = pend_q;
    req_d   = 1'b0;
    snap_en = 1'b0;
    if (pend_q) begin
      if (fw_ack) pend_d = 1'b0;
    end else if (ring) begin
      pend_d  = 1'b1;
      req_d   = 1'b1;
      snap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fw_req <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fw_req <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_cmd <= '0;
      fw_arg <= '0;
    end else if (snap_en) begin
      fw_cmd <= cmd_in;
      fw_arg <= arg_in;
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fw_req |=> !fw_req);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fw_ack) |=> (pend_q && $stable(fw_cmd) && $stable(fw_arg)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && fw_ack) |=> !pend_q);

endmodule

// File: rtl/sbmbox_top.sv
module sbmbox_top
  import sbmbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MSG_BYTES = 8,
  parameter int unsigned ARG_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(MSG_BYTES),
  localparam int unsigned WORD_W   = 8 * ARG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_alert,
  output logic              fw_req,
  output logic [7:0]        fw_cmd,
  output logic [WORD_W-1:0] fw_arg,
  input  logic              fw_ack,
  input  logic              fw_done,
  input  logic [WORD_W-1:0] fw_resp
);

  logic                   rst_sync_n;
  hit_t                   hit;
  logic [IDX_W-1:0]       out_idx;
  logic [IDX_W-1:0]       in_idx;
  logic [7:0]             ctrl_q;
  logic                   flag_q;
  logic                   pend_q;
  logic [8*MSG_BYTES-1:0] in_bytes;
  logic [8*MSG_BYTES-1:0] out_bytes;
  logic                   ring;

  sbmbox_rstsync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  always_comb begin
    hit.ctrl = (host_addr == ADDR_W'(ADR_CTRL));
    hit.stat = (host_addr == ADDR_W'(ADR_STAT));
    hit.outb = (host_addr >= ADDR_W'(ADR_OUT_BASE)) &&
               (host_addr <  ADDR_W'(ADR_OUT_BASE) + ADDR_W'(MSG_BYTES));
    hit.inb  = (host_addr >= ADDR_W'(ADR_IN_BASE)) &&
               (host_addr <  ADDR_W'(ADR_IN_BASE) + ADDR_W'(MSG_BYTES));
    hit.bell = (host_addr == ADDR_W'(ADR_BELL));
    out_idx  = IDX_W'(host_addr - ADDR_W'(ADR_OUT_BASE));
    in_idx   = IDX_W'(host_addr - ADDR_W'(ADR_IN_BASE));
    ring     = host_wr && hit.bell && host_wdata[BELL_BIT];
  end

  sbmbox_ctrlstat u_cs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl_we (host_wr && hit.ctrl),
    .stat_we (host_wr && hit.stat),
    .wdata   (host_wdata),
    .fw_done (fw_done),
    .ctrl_q  (ctrl_q),
    .flag_q  (flag_q),
    .alert   (host_alert)
  );

  sbmbox_msgbank #(.MSG_BYTES(MSG_BYTES), .ARG_BYTES(ARG_BYTES)) u_msg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_we     (host_wr && hit.inb),
    .in_idx    (in_idx),
    .wdata     (host_wdata),
    .out_load  (fw_done),
    .resp      (fw_resp),
    .in_bytes  (in_bytes),
    .out_bytes (out_bytes)
  );

  sbmbox_doorbell #(.ARG_BYTES(ARG_BYTES)) u_bell (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ring   (ring),
    .cmd_in (in_bytes[7:0]),
    .arg_in (in_bytes[8 +: WORD_W]),
    .fw_ack (fw_ack),
    .pend_q (pend_q),
    .fw_req (fw_req),
    .fw_cmd (fw_cmd),
    .fw_arg (fw_arg)
  );

  always_comb begin
    host_rdata = 8'h00;
    if (hit.ctrl)      host_rdata = ctrl_q;
    else if (hit.stat) host_rdata[FLAG_BIT] = flag_q;
    else if (hit.outb) host_rdata = out_bytes[8*out_idx +: 8];
    else if (hit.inb)  host_rdata = in_bytes[8*in_idx +: 8];
    else if (hit.bell) host_rdata[BELL_BIT] = pend_q;
  end

  assert_alert_gated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fw_done && ctrl_q[MASK_BIT] && !(host_wr && hit.ctrl)) |=> !host_alert);

endmodule

// File: tb/sbmbox_top_bench.sv
module sbmbox_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [7:0]  host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_alert;
  logic        fw_req;
  logic [7:0]  fw_cmd;
  logic [31:0] fw_arg;
  logic        fw_ack;
  logic        fw_done;
  logic [31:0] fw_resp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [39:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbmbox_top u_sbmbox_top (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_alert(host_alert),
    .fw_req(fw_req), .fw_cmd(fw_cmd), .fw_arg(fw_arg), .fw_ack(fw_ack),
    .fw_done(fw_done), .fw_resp(fw_resp)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    check(tag, {32'h0, host_rdata}, {32'h0, exp});
  endtask

  task automatic ring(input logic [7:0] cmd, input logic [31:0] arg);
    exp_q.push_back({cmd, arg});
    wr(8'h40, 8'h01);
  endtask

  task automatic ack();
    fw_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    fw_ack = 1'b0;
  endtask

  // Scoreboard monitor: each request pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && fw_req) begin
      if (exp_q.size() == 0) begin
        check("R3/R4 unexpected request", {8'h0, 32'h1}, 40'h0);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        check("R3 captured command", {fw_cmd, fw_arg}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_addr = 8'h00; host_wdata = 8'h00;
    fw_ack = 1'b0; fw_done = 1'b0; fw_resp = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1 ctrl", 8'h01, 8'h10);
    rd("R1 status", 8'h02, 8'h00);
    rd("R1 inbound", 8'h3B, 8'h00);
    rd("R1 outbound", 8'h32, 8'h00);
    rd("R1 doorbell", 8'h40, 8'h00);
    check("R1 alert", {39'h0, host_alert}, 40'h0);
    check("R1 req", {39'h0, fw_req}, 40'h0);

    // R10 control read/write
    wr(8'h01, 8'h5A); rd("R10 ctrl 5A", 8'h01, 8'h5A);
    wr(8'h01, 8'h00); rd("R10 ctrl 00", 8'h01, 8'h00);

    // R2 inbound bytes
    for (int i = 0; i < 8; i++) wr(8'h38 + 8'(i), 8'hA0 + 8'(i));
    for (int i = 0; i < 8; i++) rd("R2 inbound readback", 8'h38 + 8'(i), 8'hA0 + 8'(i));

    // R3 first command
    wr(8'h3F, 8'h80);
    wr(8'h38, 8'h02);
    wr(8'h39, 8'hEF); wr(8'h3A, 8'hBE); wr(8'h3B, 8'hAD); wr(8'h3C, 8'hDE);
    ring(8'h02, 32'hDEADBEEF);
    @(negedge clk);
    check("R3 pulse one cycle", {39'h0, fw_req}, 40'h0);
    wr(8'h39, 8'h55);
    check("R3 arg held", {fw_cmd, fw_arg}, {8'h02, 32'hDEADBEEF});

    // R4 pending interlock
    rd("R4 doorbell pending", 8'h40, 8'h01);
    wr(8'h40, 8'h01);
    @(negedge clk);
    ack();
    rd("R4 doorbell cleared", 8'h40, 8'h00);
    wr(8'h40, 8'h00);
    @(negedge clk);
    rd("R4 bit0 clear ignored", 8'h40, 8'h00);
    wr(8'h38, 8'h04);
    wr(8'h39, 8'h01); wr(8'h3A, 8'h00); wr(8'h3B, 8'h00); wr(8'h3C, 8'h00);
    ring(8'h04, 32'h00000001);
    @(negedge clk);
    ack();
    check("R3 scoreboard drained", {32'h0, 8'(exp_q.size())}, 40'h0);

    // R5 response load
    fw_resp = 32'h11223344; fw_done = 1'b1;
    @(posedge clk); @(negedge clk);
    fw_done = 1'b0;
    rd("R5 out1", 8'h31, 8'h44); rd("R5 out2", 8'h32, 8'h33);
    rd("R5 out3", 8'h33, 8'h22); rd("R5 out4", 8'h34, 8'h11);
    rd("R5 out0", 8'h30, 8'h00); rd("R5 out7", 8'h37, 8'h00);

    // R6 outbound read-only
    wr(8'h31, 8'hFF); rd("R6 out1 unchanged", 8'h31, 8'h44);
    wr(8'h30, 8'hFF); rd("R6 out0 unchanged", 8'h30, 8'h00);

    // R7/R8 status flag and alert
    rd("R7 flag set", 8'h02, 8'h02);
    check("R8 alert unmasked", {39'h0, host_alert}, 40'h1);
    wr(8'h01, 8'h10);
    check("R8 alert masked", {39'h0, host_alert}, 40'h0);
    wr(8'h01, 8'h00);
    wr(8'h02, 8'h00); rd("R7 write zero keeps", 8'h02, 8'h02);
    wr(8'h02, 8'h02); rd("R7 write one clears", 8'h02, 8'h00);
    check("R8 alert off after clear", {39'h0, host_alert}, 40'h0);
    fw_resp = 32'hCAFEF00D; fw_done = 1'b1;
    wr(8'h02, 8'h02);
    fw_done = 1'b0;
    rd("R7 set wins", 8'h02, 8'h02);
    rd("R5 second response", 8'h34, 8'hCA);

    // R9 unmapped addresses
    rd("R9 read 00", 8'h00, 8'h00); rd("R9 read 03", 8'h03, 8'h00);
    rd("R9 read 2F", 8'h2F, 8'h00); rd("R9 read 41", 8'h41, 8'h00);
    rd("R9 read FF", 8'hFF, 8'h00);
    wr(8'h03, 8'hAA); wr(8'h41, 8'h01); wr(8'h00, 8'hFF);
    rd("R9 read 03 after write", 8'h03, 8'h00);
    rd("R9 ctrl intact", 8'h01, 8'h00);
    rd("R9 status intact", 8'h02, 8'h02);
    rd("R9 doorbell intact", 8'h40, 8'h00);
    check("R9 no request", {32'h0, 8'(exp_q.size())}, 40'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule